// File: doc/BRIEF.md
# USB Endpoint to Mailbox Byte DMA Channel

This block is one DMA channel that runs in single-byte mode. It moves bytes between a USB endpoint FIFO and a host-facing mailbox port. In OUT mode it reads the endpoint receive FIFO and writes the mailbox output buffer. In IN mode it reads the mailbox input buffer and writes the endpoint transmit FIFO. It raises its own hardware transfer requests from the FIFO and mailbox status flags. Each request becomes one bus read followed by one bus write.

The channel keeps a working source address, a working destination address and a byte count, each with a reload copy. In OUT mode, the end of a received packet reloads the working registers from their copies. The end of a packet is seen as the falling edge of the endpoint packet-ready flag. In IN mode the count is loaded with the packet size, and the byte that exhausts the count does the reload. Both events set the channel interrupt flag. In OUT mode the packet-end event can also disable the channel.

Top module: `ep_mbox_dma`

## Requirements
- R1: After reset, no bus read or write is driven, the interrupt flag and channel enable are 0, and the source, destination and count registers read 0.
- R2: A pulse on cfg_load_i writes the configured source, destination and count into both the working registers and their reload copies. A pulse on en_set_i sets the channel enable.
- R3: With dir_in_i = 0 (OUT), a transfer starts only when the channel is enabled, usb_req_en_i = 1, out_fifo_nempty_i = 1 and mbox_obuf_full_i = 0.
- R4: With dir_in_i = 1 (IN), a transfer starts only when the channel is enabled, usb_req_en_i = 1, in_pkt_rdy_i = 0, mbox_ibuf_full_i = 1 and mbox_ibuf_cmd_i = 0. A buffer that holds a command never starts a transfer.
- R5: While the channel enable is 0, no transfer starts, whatever the status inputs are.
- R6: The block samples the request in an idle cycle. If the request is present, the next cycle is a read with bus_addr_o equal to the source register. The cycle after that is a write with bus_addr_o equal to the destination register and bus_wdata_o equal to the byte that was read. The cycle after a write is always idle, so a request held high gives one read every third cycle.
- R7: When a write completes, the source increments by 1 if src_inc_i = 1, the destination increments by 1 if dst_inc_i = 1, and the count decrements by 1 (modulo 2^CNT_W).
- R8: In OUT mode, a 1-to-0 transition of out_pkt_rdy_i reloads source, destination and count from their copies and sets the interrupt flag. The reload takes priority over an update from a write that completes in the same cycle.
- R9: With reload_dis_i = 1, neither the packet-end event nor count exhaustion reloads the registers. The interrupt flag is still set.
- R10: In OUT mode with auto_dis_i = 1, the packet-end transition clears the channel enable. This clear wins over an en_set_i pulse in the same cycle.
- R11: In IN mode, a write that completes while the count is 1 reloads the registers and sets the interrupt flag. A falling out_pkt_rdy_i in IN mode has no effect.
- R12: The interrupt flag stays set until an irq_clr_i pulse clears it. A new event in the same cycle as irq_clr_i keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load working and reload registers |
| cfg_src_i | input | ADDR_W | Source address to load |
| cfg_dst_i | input | ADDR_W | Destination address to load |
| cfg_cnt_i | input | CNT_W | Byte count to load |
| src_inc_i | input | 1 | Increment source after each byte |
| dst_inc_i | input | 1 | Increment destination after each byte |
| dir_in_i | input | 1 | 0 = OUT (FIFO to mailbox), 1 = IN (mailbox to FIFO) |
| usb_req_en_i | input | 1 | Enable for hardware requests from USB status |
| reload_dis_i | input | 1 | Suppress automatic reload |
| auto_dis_i | input | 1 | Clear enable on OUT packet end |
| en_set_i | input | 1 | Set channel enable |
| irq_clr_i | input | 1 | Clear interrupt flag |
| out_fifo_nempty_i | input | 1 | Endpoint receive FIFO holds data |
| mbox_obuf_full_i | input | 1 | Mailbox output buffer occupied |
| out_pkt_rdy_i | input | 1 | Endpoint received-packet flag |
| in_pkt_rdy_i | input | 1 | Endpoint transmit packet complete (FIFO full) |
| mbox_ibuf_full_i | input | 1 | Mailbox input buffer occupied |
| mbox_ibuf_cmd_i | input | 1 | Input buffer content is a command |
| bus_rdata_i | input | DATA_W | Read data for the read cycle |
| bus_rd_o | output | 1 | Read cycle |
| bus_wr_o | output | 1 | Write cycle |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Write data |
| irq_o | output | 1 | Channel interrupt flag |
| ch_en_o | output | 1 | Channel enable |
| src_o | output | ADDR_W | Working source address |
| dst_o | output | ADDR_W | Working destination address |
| cnt_o | output | CNT_W | Working byte count |

## Verification
The bench builds the channel with 8-bit addresses and data and a 4-bit count. This width lets count exhaustion be swept over every small packet size, and it makes count wraparound in OUT mode reachable. It drives every combination of the OUT gating flags and of the IN gating flags. It checks the source and destination increment options in all four combinations. It also sets up a packet-end edge that lands on the same clock edge as a completing write, so the reload priority is tested. Read data is a fixed function of the address, which lets each written byte be predicted arithmetically.

// File: rtl/ep_mbox_dma_pkg.sv
package ep_mbox_dma_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_RD   = 2'd1,
    XS_WR   = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/ep_mbox_dma_req.sv
module ep_mbox_dma_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_in_i,
  input  logic usb_req_en_i,
  input  logic ch_en_i,
  input  logic out_fifo_nempty_i,
  input  logic mbox_obuf_full_i,
  input  logic in_pkt_rdy_i,
  input  logic mbox_ibuf_full_i,
  input  logic mbox_ibuf_cmd_i,
  input  logic out_pkt_rdy_i,
  output logic req_o,
  output logic pkt_end_o
);
  logic pkt_rdy_q;
  logic out_ok, in_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pkt_rdy_q <= 1'b0;
    else         pkt_rdy_q <= out_pkt_rdy_i;
  end

  assign out_ok    = out_fifo_nempty_i & ~mbox_obuf_full_i;
  assign in_ok     = ~in_pkt_rdy_i & mbox_ibuf_full_i & ~mbox_ibuf_cmd_i;
  assign req_o     = ch_en_i & usb_req_en_i & (dir_in_i ? in_ok : out_ok);
  // packet end only meaningful for receive direction
  assign pkt_end_o = ~dir_in_i & pkt_rdy_q & ~out_pkt_rdy_i;
endmodule

// File: rtl/ep_mbox_dma_xfer.sv
module ep_mbox_dma_xfer
  import ep_mbox_dma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              done_o
);
  xfer_state_e state_q, state_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE: if (req_i) state_d = XS_RD;
      XS_RD:   state_d = XS_WR;
      XS_WR:   state_d = XS_IDLE;  // request resampled only from idle
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == XS_RD) data_q <= bus_rdata_i;
    end
  end

  assign bus_rd_o    = (state_q == XS_RD);
  assign bus_wr_o    = (state_q == XS_WR);
  assign done_o      = bus_wr_o;
  assign bus_addr_o  = bus_rd_o ? src_i : (bus_wr_o ? dst_i : '0);
  assign bus_wdata_o = bus_wr_o ? data_q : '0;
endmodule

// File: rtl/ep_mbox_dma_regs.sv
module ep_mbox_dma_regs #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  input  logic [CNT_W-1:0]  cfg_cnt_i,
  input  logic              src_inc_i,
  input  logic              dst_inc_i,
  input  logic              dir_in_i,
  input  logic              reload_dis_i,
  input  logic              auto_dis_i,
  input  logic              en_set_i,
  input  logic              irq_clr_i,
  input  logic              done_i,
  input  logic              pkt_end_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [ADDR_W-1:0] src_q, dst_q, src_rl_q, dst_rl_q;
  logic [CNT_W-1:0]  cnt_q, cnt_rl_q;
  logic              en_q, irq_q;
  logic              exhaust, evt, reload;

  assign exhaust = done_i & dir_in_i & (cnt_q == CNT_LAST);
  assign evt     = pkt_end_i | exhaust;
  assign reload  = evt & ~reload_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      src_rl_q <= '0;
      dst_rl_q <= '0;
      cnt_rl_q <= '0;
    end else if (cfg_load_i) begin
      src_q    <= cfg_src_i;
      dst_q    <= cfg_dst_i;
      cnt_q    <= cfg_cnt_i;
      src_rl_q <= cfg_src_i;
      dst_rl_q <= cfg_dst_i;
      cnt_rl_q <= cfg_cnt_i;
    end else if (reload) begin
      src_q <= src_rl_q;
      dst_q <= dst_rl_q;
      cnt_q <= cnt_rl_q;
    end else if (done_i) begin
      src_q <= src_q + ADDR_W'(src_inc_i);
      dst_q <= dst_q + ADDR_W'(dst_inc_i);
      cnt_q <= cnt_q - CNT_LAST;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (pkt_end_i && auto_dis_i) en_q <= 1'b0;
      else if (en_set_i)           en_q <= 1'b1;
      if (evt)            irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/ep_mbox_dma.sv
module ep_mbox_dma #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  input  logic [CNT_W-1:0]  cfg_cnt_i,
  input  logic              src_inc_i,
  input  logic              dst_inc_i,
  input  logic              dir_in_i,
  input  logic              usb_req_en_i,
  input  logic              reload_dis_i,
  input  logic              auto_dis_i,
  input  logic              en_set_i,
  input  logic              irq_clr_i,
  input  logic              out_fifo_nempty_i,
  input  logic              mbox_obuf_full_i,
  input  logic              out_pkt_rdy_i,
  input  logic              in_pkt_rdy_i,
  input  logic              mbox_ibuf_full_i,
  input  logic              mbox_ibuf_cmd_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              irq_o,
  output logic              ch_en_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic req, pkt_end, done;

  ep_mbox_dma_req u_req (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .dir_in_i          (dir_in_i),
    .usb_req_en_i      (usb_req_en_i),
    .ch_en_i           (ch_en_o),
    .out_fifo_nempty_i (out_fifo_nempty_i),
    .mbox_obuf_full_i  (mbox_obuf_full_i),
    .in_pkt_rdy_i      (in_pkt_rdy_i),
    .mbox_ibuf_full_i  (mbox_ibuf_full_i),
    .mbox_ibuf_cmd_i   (mbox_ibuf_cmd_i),
    .out_pkt_rdy_i     (out_pkt_rdy_i),
    .req_o             (req),
    .pkt_end_o         (pkt_end)
  );

  ep_mbox_dma_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .src_i       (src_o),
    .dst_i       (dst_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_rd_o    (bus_rd_o),
    .bus_wr_o    (bus_wr_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .done_o      (done)
  );

  ep_mbox_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_load_i   (cfg_load_i),
    .cfg_src_i    (cfg_src_i),
    .cfg_dst_i    (cfg_dst_i),
    .cfg_cnt_i    (cfg_cnt_i),
    .src_inc_i    (src_inc_i),
    .dst_inc_i    (dst_inc_i),
    .dir_in_i     (dir_in_i),
    .reload_dis_i (reload_dis_i),
    .auto_dis_i   (auto_dis_i),
    .en_set_i     (en_set_i),
    .irq_clr_i    (irq_clr_i),
    .done_i       (done),
    .pkt_end_i    (pkt_end),
    .src_o        (src_o),
    .dst_o        (dst_o),
    .cnt_o        (cnt_o),
    .en_o         (ch_en_o),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/ep_mbox_dma_chk.sv
module ep_mbox_dma_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dir_in_i,
  input logic usb_req_en_i,
  input logic out_fifo_nempty_i,
  input logic mbox_obuf_full_i,
  input logic in_pkt_rdy_i,
  input logic mbox_ibuf_full_i,
  input logic mbox_ibuf_cmd_i,
  input logic out_pkt_rdy_i,
  input logic auto_dis_i,
  input logic bus_rd_o,
  input logic bus_wr_o,
  input logic irq_o,
  input logic ch_en_o
);
  p_rw_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  p_rd_then_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o |=> bus_wr_o);

  p_wr_then_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o |=> (!bus_rd_o && !bus_wr_o));

  p_gate_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o |-> $past(ch_en_o));

  p_out_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && !$past(dir_in_i)) |->
      $past(usb_req_en_i && out_fifo_nempty_i && !mbox_obuf_full_i));

  p_in_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && $past(dir_in_i)) |->
      $past(usb_req_en_i && !in_pkt_rdy_i && mbox_ibuf_full_i && !mbox_ibuf_cmd_i));

  p_pkt_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !dir_in_i && $fell(out_pkt_rdy_i)) |=> irq_o);

  p_auto_dis_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !dir_in_i && auto_dis_i && $fell(out_pkt_rdy_i)) |=> !ch_en_o);
endmodule

bind ep_mbox_dma ep_mbox_dma_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .dir_in_i          (dir_in_i),
  .usb_req_en_i      (usb_req_en_i),
  .out_fifo_nempty_i (out_fifo_nempty_i),
  .mbox_obuf_full_i  (mbox_obuf_full_i),
  .in_pkt_rdy_i      (in_pkt_rdy_i),
  .mbox_ibuf_full_i  (mbox_ibuf_full_i),
  .mbox_ibuf_cmd_i   (mbox_ibuf_cmd_i),
  .out_pkt_rdy_i     (out_pkt_rdy_i),
  .auto_dis_i        (auto_dis_i),
  .bus_rd_o          (bus_rd_o),
  .bus_wr_o          (bus_wr_o),
  .irq_o             (irq_o),
  .ch_en_o           (ch_en_o)
);

// File: tb/ep_mbox_dma_test.sv
module ep_mbox_dma_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 0, src_inc = 0, dst_inc = 0, dir_in = 0, usb_req_en = 0;
  logic       reload_dis = 0, auto_dis = 0, en_set = 0, irq_clr = 0;
  logic       fifo_ne = 0, obuf_full = 0, out_rdy = 0, in_rdy = 0, ibuf_full = 0, ibuf_cmd = 0;
  logic [7:0] cfg_src = 0, cfg_dst = 0;
  logic [3:0] cfg_cnt = 0;
  logic [7:0] rdata, addr, wdata, src, dst;
  logic [3:0] cnt;
  logic       rd, wr, irq, en;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  assign rdata = addr ^ 8'hA5;

  ep_mbox_dma #(.ADDR_W(8), .DATA_W(8), .CNT_W(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_src_i(cfg_src),
    .cfg_dst_i(cfg_dst), .cfg_cnt_i(cfg_cnt), .src_inc_i(src_inc), .dst_inc_i(dst_inc),
    .dir_in_i(dir_in), .usb_req_en_i(usb_req_en), .reload_dis_i(reload_dis),
    .auto_dis_i(auto_dis), .en_set_i(en_set), .irq_clr_i(irq_clr),
    .out_fifo_nempty_i(fifo_ne), .mbox_obuf_full_i(obuf_full), .out_pkt_rdy_i(out_rdy),
    .in_pkt_rdy_i(in_rdy), .mbox_ibuf_full_i(ibuf_full), .mbox_ibuf_cmd_i(ibuf_cmd),
    .bus_rdata_i(rdata), .bus_rd_o(rd), .bus_wr_o(wr), .bus_addr_o(addr),
    .bus_wdata_o(wdata), .irq_o(irq), .ch_en_o(en), .src_o(src), .dst_o(dst), .cnt_o(cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic load(input logic [7:0] s, input logic [7:0] d, input logic [3:0] c);
    cfg_src = s; cfg_dst = d; cfg_cnt = c; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
  endtask

  task automatic set_req(input bit in_dir);
    dir_in = in_dir;
    if (in_dir) begin in_rdy = 0; ibuf_full = 1; ibuf_cmd = 0; end
    else begin fifo_ne = 1; obuf_full = 0; end
    usb_req_en = 1;
  endtask

  // one byte: read, write, then regs updated at the following negedge
  task automatic xfer(input bit in_dir, input logic [7:0] es, input logic [7:0] ed);
    set_req(in_dir);
    @(negedge clk);
    eq("R6 rd", rd, 1);
    eq("R6 rd addr", addr, es);
    usb_req_en = 0;
    @(negedge clk);
    eq("R6 wr", wr, 1);
    eq("R6 wr addr", addr, ed);
    eq("R6 wdata", wdata, es ^ 8'hA5);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    eq("R1 rd", rd, 0); eq("R1 wr", wr, 0); eq("R1 irq", irq, 0); eq("R1 en", en, 0);
    eq("R1 src", src, 0); eq("R1 dst", dst, 0); eq("R1 cnt", cnt, 0);

    // R2 load
    load(8'h10, 8'h80, 4'd9);
    eq("R2 src", src, 8'h10); eq("R2 dst", dst, 8'h80); eq("R2 cnt", cnt, 9);

    // R5 disabled channel ignores requests
    set_req(0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      eq("R5 no rd while disabled", rd, 0);
    end
    usb_req_en = 0;
    en_set = 1;
    @(negedge clk);
    en_set = 0;
    eq("R2 enable", en, 1);

    // R7 increments over all option combinations
    for (int k = 0; k < 4; k++) begin
      logic [7:0] s0, d0;
      logic [3:0] c0;
      s0 = src; d0 = dst; c0 = cnt;
      src_inc = k[0]; dst_inc = k[1];
      xfer(0, s0, d0);
      eq("R7 src", src, 8'(s0 + k[0]));
      eq("R7 dst", dst, 8'(d0 + k[1]));
      eq("R7 cnt", cnt, 4'(c0 - 1));
    end

    // R3 OUT gating sweep
    dir_in = 0;
    for (int v = 0; v < 8; v++) begin
      fifo_ne = v[1]; obuf_full = v[2]; usb_req_en = v[0];
      @(negedge clk);
      eq("R3 out gate", rd, (v[0] && v[1] && !v[2]) ? 1 : 0);
      usb_req_en = 0;
      repeat (2) @(negedge clk);
    end

    // R4 IN gating sweep
    dir_in = 1;
    for (int v = 0; v < 16; v++) begin
      in_rdy = v[1]; ibuf_full = v[2]; ibuf_cmd = v[3]; usb_req_en = v[0];
      @(negedge clk);
      eq("R4 in gate", rd, (v[0] && !v[1] && v[2] && !v[3]) ? 1 : 0);
      usb_req_en = 0;
      repeat (2) @(negedge clk);
    end

    // R6 held request: one read every third cycle
    load(8'h50, 8'h60, 4'd12);
    src_inc = 1; dst_inc = 0;
    set_req(0);
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      eq("R6 cadence rd", rd, (i % 3 == 1) ? 1 : 0);
      eq("R6 cadence wr", wr, (i % 3 == 2) ? 1 : 0);
    end
    usb_req_en = 0;
    eq("R7 three bytes src", src, 8'h53);
    eq("R7 three bytes cnt", cnt, 9);

    // R8 OUT packet end, reload wins over same-cycle write completion
    src_inc = 1; dst_inc = 1;
    load(8'h20, 8'h40, 4'd5);
    xfer(0, 8'h20, 8'h40);
    pulse_clr();
    eq("R12 cleared", irq, 0);
    out_rdy = 1;
    @(negedge clk);
    set_req(0);
    @(negedge clk);
    eq("R8 rd", rd, 1);
    usb_req_en = 0;
    @(negedge clk);
    eq("R8 wr", wr, 1);
    out_rdy = 0;
    @(negedge clk);
    eq("R8 reload src", src, 8'h20); eq("R8 reload dst", dst, 8'h40);
    eq("R8 reload cnt", cnt, 5); eq("R8 irq", irq, 1); eq("R8 en kept", en, 1);
    repeat (3) @(negedge clk);
    eq("R12 irq held", irq, 1);

    // R9 reload suppressed, flag still set
    xfer(0, 8'h20, 8'h40);
    pulse_clr();
    reload_dis = 1; out_rdy = 1;
    @(negedge clk);
    out_rdy = 0;
    @(negedge clk);
    eq("R9 src kept", src, 8'h21); eq("R9 cnt kept", cnt, 4); eq("R9 irq", irq, 1);
    reload_dis = 0;

    // R12 event same cycle as clear keeps flag
    out_rdy = 1;
    @(negedge clk);
    out_rdy = 0; irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    eq("R12 set wins", irq, 1);

    // R10 auto disable beats en_set
    pulse_clr();
    auto_dis = 1; out_rdy = 1;
    @(negedge clk);
    out_rdy = 0; en_set = 1;
    @(negedge clk);
    en_set = 0; auto_dis = 0;
    eq("R10 disabled", en, 0); eq("R10 irq", irq, 1);
    set_req(0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      eq("R10 no rd after disable", rd, 0);
    end
    usb_req_en = 0;
    en_set = 1;
    @(negedge clk);
    en_set = 0;

    // R11 IN exhaustion over packet sizes
    src_inc = 1; dst_inc = 0;
    for (int n = 1; n <= 4; n++) begin
      load(8'h30, 8'h90, 4'(n));
      pulse_clr();
      for (int k = 1; k <= n; k++) begin
        xfer(1, 8'(8'h30 + k - 1), 8'h90);
        if (k < n) begin
          eq("R11 cnt mid", cnt, n - k); eq("R11 no irq mid", irq, 0);
        end else begin
          eq("R11 cnt reload", cnt, n); eq("R11 src reload", src, 8'h30);
          eq("R11 irq", irq, 1);
        end
      end
    end

    // R9 on IN exhaustion
    load(8'h30, 8'h90, 4'd2);
    pulse_clr();
    reload_dis = 1;
    xfer(1, 8'h30, 8'h90);
    xfer(1, 8'h31, 8'h90);
    eq("R9 in cnt", cnt, 0); eq("R9 in src", src, 8'h32); eq("R9 in irq", irq, 1);
    reload_dis = 0;

    // R11 falling packet flag ignored in IN mode
    pulse_clr();
    dir_in = 1; out_rdy = 1;
    @(negedge clk);
    out_rdy = 0;
    @(negedge clk);
    @(negedge clk);
    eq("R11 fall ignored irq", irq, 0); eq("R11 fall ignored src", src, 8'h32);
    eq("R11 fall ignored en", en, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule